// File: doc/BRIEF.md
# Status-Code Driven Two-Wire Serial Slave

This block is the slave side of a two-wire serial bus with open-drain clock and data lines. It samples both lines and detects START and STOP conditions. It compares each address byte with a programmed 7-bit address, or with the broadcast address 00h. It then receives data bytes or sends them out. Software reaches it through four byte-wide registers: control, status, data and own address.

Every significant bus event leaves a status code and sets an interrupt flag. For byte-level events the block also stretches the clock, holding SCL low after the acknowledge clock until software clears the flag. Software therefore reads the status code and decides what to do next. It can fetch a received byte, load the next byte to send, or change whether bytes are acknowledged, and then it clears the flag to let the bus run on.

Register map (register address, then contents):
- 0, control: bit 0 enables the core, bit 1 enables slave operation, bit 2 enables acknowledging, and bit 3 is the interrupt flag. Writing this register with bit 3 at 0 clears the flag; writing 1 does not set it.
- 1, status: a 5-bit code in bits 7:3.
- 2, data.
- 3, own address: address in bits 7:1, bit 0 enables the broadcast address.

Top module: `i2c_status_slave`

## Requirements
- R1: After reset the control register reads 00h, status reads F8h, data and own address read 00h, the flag is clear and neither SCL nor SDA is pulled low.
- R2: The status register reads F8h whenever the interrupt flag is clear, and its bits 2:0 always read as zero.
- R3: While the flag is set, the status code does not change, including across control writes that keep bit 3 at 1. A control write with bit 3 at 0 clears the flag and returns status to F8h.
- R4: With core, slave and acknowledge enabled, an address byte whose bits 7:1 equal own-address bits 7:1 is ACKed and posts 60h (bit 0 = 0, write) or A8h (bit 0 = 1, read). Address byte 00h is ACKed with code 70h only when own-address bit 0 is 1. Any other address is not ACKed and posts nothing.
- R5: Writes to the data register take effect only while the flag is set. The data register is stable while the flag is set, apart from such writes. When a byte-event code is posted, the register takes the byte that just crossed the bus.
- R6: In receive mode each data byte is ACKed with code 80h when acknowledge is enabled. Otherwise it is NACKed with code 88h, and the block then ignores the bus until the next START.
- R7: After the ninth clock of an address or data byte that posts a code, the block holds SCL low while the flag is set and releases it within one cycle of the flag clearing.
- R8: In transmit mode, clearing the flag starts sending the data register MSB first. The master's ACK posts B8h. A NACK posts C0h, after which SDA stays released and the bus is ignored until the next START.
- R9: The block changes its own SDA drive only while the sampled SCL is low.
- R10: With the core or slave-enable bit clear, the block acknowledges nothing, raises no flag and pulls neither line low.
- R11: A STOP or repeated START while addressed in receive or transmit mode posts A0h without stretching SCL.
- R12: With acknowledge disabled, the block does not ACK its own address and posts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 2 | Register select: 0 control, 1 status, 2 data, 3 own address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational on regAddr) |
| sclIn | input | 1 | Sampled SCL line level |
| sdaIn | input | 1 | Sampled SDA line level |
| sclPullLow | output | 1 | 1 pulls SCL low (clock stretch) |
| sdaPullLow | output | 1 | 1 pulls SDA low |
| irq | output | 1 | Interrupt flag |

## Verification
The checker watches several rules on every cycle:
- status reads F8h whenever the flag is clear;
- the status code and the data register stay frozen while the flag is set;
- clock stretching only happens while the flag is set;
- the SDA drive never changes while the sampled clock is high;
- a disabled block never holds the clock.

Only the bench's bus scenarios can show the rest:
- which address bytes are acknowledged, checked by a sweep of all 128 write addresses with the broadcast address enabled;
- the order of status codes through receive, transmit, NACK, repeated START and STOP sequences;
- the byte values that cross the bus in each direction.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 2);

  typedef enum logic [2:0] {
    MODE_IDLE,
    MODE_ADDR,
    MODE_RX,
    MODE_TX,
    MODE_SKIP
  } busModeT;

  // status codes, upper five bits of the status byte
  localparam logic [4:0] CODE_SLA_W   = 5'h0C; // 60h
  localparam logic [4:0] CODE_GCALL   = 5'h0E; // 70h
  localparam logic [4:0] CODE_RX_ACK  = 5'h10; // 80h
  localparam logic [4:0] CODE_RX_NACK = 5'h11; // 88h
  localparam logic [4:0] CODE_END     = 5'h14; // A0h
  localparam logic [4:0] CODE_SLA_R   = 5'h15; // A8h
  localparam logic [4:0] CODE_TX_ACK  = 5'h17; // B8h
  localparam logic [4:0] CODE_TX_NACK = 5'h18; // C0h
  localparam logic [4:0] CODE_NONE    = 5'h1F; // F8h

  typedef struct packed {
    logic       shiftIn;  // shift the sampled SDA into the byte register
    logic       loadTx;   // copy the data register into the shifter
    logic       post;     // post a status code and raise the flag
    logic       hold;     // posted event stretches SCL and captures the byte
    logic [4:0] code;
  } strobeT;

endpackage

// File: rtl/i2cs_linesync.sv
module i2cs_linesync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [1:0] linePipe [SYNC_STAGES];
  logic sclPrev, sdaPrev;

  // stage chain, one entry per synchronizer stage
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) linePipe[g] <= 2'b11;
      else if (g == 0) linePipe[g] <= {sclIn, sdaIn};
      else linePipe[g] <= linePipe[(g == 0) ? 0 : g - 1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclLvl;
      sdaPrev <= sdaLvl;
    end
  end

  assign sclLvl  = linePipe[TOP][1];
  assign sdaLvl  = linePipe[TOP][0];
  assign sclRise = sclLvl & ~sclPrev;
  assign sclFall = ~sclLvl & sclPrev;
  assign startEv = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopEv  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;

endmodule

// File: rtl/i2cs_datapath.sv
module i2cs_datapath
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  input  strobeT            strb,
  input  logic              sdaLvl,
  output logic              busEn,
  output logic              ackEn,
  output logic [BYTE_W-1:0] ownAddr,
  output logic [BYTE_W-1:0] dataReg,
  output logic [BYTE_W-1:0] shiftReg,
  output logic              flag,
  output logic              flagClr,
  output logic              dataWrite,
  output logic [4:0]        statusCode,
  output logic              sclPullLow
);
  logic coreOn, slvOn, holdReg;
  logic wrCtrl, wrData, wrOwn, postOk;

  assign wrCtrl    = regWrEn && (regAddr == 2'd0);
  assign wrData    = regWrEn && (regAddr == 2'd2);
  assign wrOwn     = regWrEn && (regAddr == 2'd3);
  assign flagClr   = wrCtrl && !regWrData[3] && flag;
  assign dataWrite = wrData && flag;
  assign postOk    = strb.post && !flag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coreOn     <= 1'b0;
      slvOn      <= 1'b0;
      ackEn      <= 1'b0;
      flag       <= 1'b0;
      holdReg    <= 1'b0;
      statusCode <= CODE_NONE;
      ownAddr    <= '0;
      dataReg    <= '0;
      shiftReg   <= '0;
    end else begin
      if (wrCtrl) begin
        coreOn <= regWrData[0];
        slvOn  <= regWrData[1];
        ackEn  <= regWrData[2];
      end
      if (postOk) begin
        flag       <= 1'b1;
        holdReg    <= strb.hold;
        statusCode <= strb.code;
      end else if (flagClr) begin
        flag       <= 1'b0;
        statusCode <= CODE_NONE;
      end
      if (wrOwn) ownAddr <= regWrData;
      if (dataWrite) dataReg <= regWrData;
      else if (postOk && strb.hold) dataReg <= shiftReg;
      if (strb.loadTx) shiftReg <= dataReg;
      else if (strb.shiftIn) shiftReg <= {shiftReg[BYTE_W-2:0], sdaLvl};
    end
  end

  assign busEn      = coreOn & slvOn;
  assign sclPullLow = flag & holdReg & busEn;

  always_comb begin
    case (regAddr)
      2'd0:    regRdData = {4'b0000, flag, ackEn, slvOn, coreOn};
      2'd1:    regRdData = {statusCode, 3'b000};
      2'd2:    regRdData = dataReg;
      default: regRdData = ownAddr;
    endcase
  end

endmodule

// File: rtl/i2cs_control.sv
module i2cs_control
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busEn,
  input  logic              ackEn,
  input  logic [BYTE_W-1:0] ownAddr,
  input  logic [BYTE_W-1:0] shiftReg,
  input  logic              dataMsb,
  input  logic              flagClr,
  input  logic              sdaLvl,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startEv,
  input  logic              stopEv,
  output strobeT            strb,
  output logic              sdaPullLow
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

  busModeT          mode;
  logic [CNT_W-1:0] bitCnt;
  logic [4:0]       pendCode;
  logic ackDrive, txActive, txBit, nackSeen;
  logic addressed, active, ownHit, gcHit, accept;

  assign addressed = (mode == MODE_RX) || (mode == MODE_TX);
  assign active    = addressed || (mode == MODE_ADDR);
  assign ownHit    = shiftReg[BYTE_W-1:1] == ownAddr[BYTE_W-1:1];
  assign gcHit     = ownAddr[0] && (shiftReg == '0);
  assign accept    = ackEn && (gcHit || ownHit);

  always_comb begin
    strb = '0;
    if (busEn) begin
      if (startEv || stopEv) begin
        if (addressed) begin
          strb.post = 1'b1;
          strb.code = CODE_END;
        end
      end else if (sclRise && active && bitCnt < LAST_BIT) begin
        strb.shiftIn = 1'b1;
      end else if (sclFall && active && bitCnt == ACK_BIT) begin
        strb.post = 1'b1;
        strb.hold = 1'b1;
        if (mode == MODE_TX) strb.code = nackSeen ? CODE_TX_NACK : CODE_TX_ACK;
        else strb.code = pendCode;
      end else if (flagClr && mode == MODE_TX && bitCnt == '0 && !txActive) begin
        strb.loadTx = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode     <= MODE_IDLE;
      bitCnt   <= '0;
      pendCode <= CODE_NONE;
      ackDrive <= 1'b0;
      txActive <= 1'b0;
      txBit    <= 1'b1;
      nackSeen <= 1'b0;
    end else if (!busEn || startEv || stopEv) begin
      mode     <= (busEn && startEv) ? MODE_ADDR : MODE_IDLE;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      txActive <= 1'b0;
    end else begin
      if (sclRise && active) begin
        if (bitCnt == LAST_BIT) nackSeen <= sdaLvl;
        if (bitCnt != ACK_BIT) bitCnt <= bitCnt + 1'b1;
      end
      if (sclFall && active) begin
        if (bitCnt != '0 && bitCnt < LAST_BIT && txActive) txBit <= shiftReg[BYTE_W-1];
        if (bitCnt == LAST_BIT) begin
          case (mode)
            MODE_ADDR: begin
              if (accept) begin
                ackDrive <= 1'b1;
                pendCode <= gcHit ? CODE_GCALL : (shiftReg[0] ? CODE_SLA_R : CODE_SLA_W);
              end else begin
                mode <= MODE_SKIP;
              end
            end
            MODE_RX: begin
              ackDrive <= ackEn;
              pendCode <= ackEn ? CODE_RX_ACK : CODE_RX_NACK;
            end
            default: txActive <= 1'b0;
          endcase
        end
        if (bitCnt == ACK_BIT) begin
          ackDrive <= 1'b0;
          bitCnt   <= '0;
          case (mode)
            MODE_ADDR: mode <= (pendCode == CODE_SLA_R) ? MODE_TX : MODE_RX;
            MODE_RX:   if (pendCode == CODE_RX_NACK) mode <= MODE_SKIP;
            default:   if (nackSeen) mode <= MODE_SKIP;
          endcase
        end
      end
      if (strb.loadTx) begin
        txActive <= 1'b1;
        txBit    <= dataMsb;
      end
    end
  end

  assign sdaPullLow = ackDrive | (txActive & ~txBit);

endmodule

// File: rtl/i2c_status_slave.sv
module i2c_status_slave
  import i2cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regAddr,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sclPullLow,
  output logic       sdaPullLow,
  output logic       irq
);
  strobeT            strb;
  logic              sclLvl, sdaLvl, sclRise, sclFall, startEv, stopEv;
  logic              busEn, ackEn, flag, flagClr, dataWrite;
  logic [BYTE_W-1:0] ownAddr, dataReg, shiftReg;
  logic [4:0]        statusCode;

  i2cs_linesync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv)
  );

  i2cs_datapath dp_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .strb(strb), .sdaLvl(sdaLvl),
    .busEn(busEn), .ackEn(ackEn), .ownAddr(ownAddr), .dataReg(dataReg),
    .shiftReg(shiftReg), .flag(flag), .flagClr(flagClr), .dataWrite(dataWrite),
    .statusCode(statusCode), .sclPullLow(sclPullLow)
  );

  i2cs_control ctl_i (
    .clk(clk), .rstN(rstN), .busEn(busEn), .ackEn(ackEn), .ownAddr(ownAddr),
    .shiftReg(shiftReg), .dataMsb(dataReg[BYTE_W-1]), .flagClr(flagClr),
    .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall), .startEv(startEv),
    .stopEv(stopEv), .strb(strb), .sdaPullLow(sdaPullLow)
  );

  assign irq = flag;

endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
  input logic       clk,
  input logic       rstN,
  input logic       flag,
  input logic [4:0] statusCode,
  input logic [7:0] dataReg,
  input logic       dataWrite,
  input logic       sclPullLow,
  input logic       sdaPullLow,
  input logic       sclLvl,
  input logic       busEn
);

  assert_idle_code_R2: assert property (@(posedge clk) disable iff (!rstN)
    !flag |-> statusCode == 5'h1F)
    else $error("status not F8h while flag clear");

  assert_status_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (flag && $past(flag)) |-> $stable(statusCode))
    else $error("status changed while flag set");

  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (flag && $past(flag) && !$past(dataWrite)) |-> $stable(dataReg))
    else $error("data register moved while flag set");

  assert_stretch_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    sclPullLow |-> flag)
    else $error("SCL held without flag");

  assert_sda_scl_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> (!sclLvl || !busEn))
    else $error("SDA drive changed while SCL high");

  assert_off_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busEn |-> !sclPullLow)
    else $error("disabled block holds SCL");

endmodule

bind i2c_status_slave i2cs_checker chk_i (
  .clk(clk), .rstN(rstN), .flag(flag), .statusCode(statusCode),
  .dataReg(dataReg), .dataWrite(dataWrite), .sclPullLow(sclPullLow),
  .sdaPullLow(sdaPullLow), .sclLvl(sclLvl), .busEn(busEn)
);

// File: tb/i2c_status_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_status_slave_tb_top;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic mScl = 1'b1, mSda = 1'b1;
  logic sclPullLow, sdaPullLow, irq;
  logic sclLine, sdaLine;
  int total = 0, bad = 0, sdaViol = 0;
  logic finished = 1'b0;

  assign sclLine = mScl & ~sclPullLow;
  assign sdaLine = mSda & ~sdaPullLow;

  always #4 clk = ~clk;

  i2c_status_slave dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclPullLow(sclPullLow), .sdaPullLow(sdaPullLow), .irq(irq)
  );

  // R9 monitor: the slave's SDA drive must not move while the line clock is high
  logic prevSdaDrv = 1'b0;
  always @(negedge clk) begin
    if (rstN && sdaPullLow != prevSdaDrv && sclLine) sdaViol++;
    prevSdaDrv <= sdaPullLow;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic sclHigh();
    mScl = 1'b1;
    while (!sclLine) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; waitQ(); sclHigh(); waitQ();
    mSda = 1'b0; waitQ(); mScl = 1'b0; waitQ();
  endtask

  task automatic busStop();
    mSda = 1'b0; waitQ(); sclHigh(); waitQ();
    mSda = 1'b1; waitQ();
  endtask

  task automatic sendBit(input logic b);
    mSda = b; waitQ(); sclHigh(); waitQ(); mScl = 1'b0; waitQ();
  endtask

  task automatic recvBit(output logic b);
    mSda = 1'b1; waitQ(); sclHigh(); waitQ(); b = sdaLine; mScl = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] d, output logic ackB);
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    recvBit(ackB);
  endtask

  task automatic recvByte(output logic [7:0] d, input logic ackOut);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recvBit(b);
      d[i] = b;
    end
    sendBit(ackOut);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] st, d;
    logic ackB;
    logic hit;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regRead(2'd0, d); check("R1 ctrl", d, 8'h00);
    regRead(2'd1, st); check("R1 status", st, 8'hF8);
    regRead(2'd2, d); check("R1 data", d, 8'h00);
    regRead(2'd3, d); check("R1 own", d, 8'h00);
    check("R1 pins", {irq, sclPullLow, sdaPullLow}, 3'b000);

    // R10 disabled slave: slave-enable bit clear
    regWrite(2'd3, 8'h55);
    regWrite(2'd0, 8'h05);
    busStart(); sendByte(8'h54, ackB);
    check("R10 no ack or flag", {ackB, irq, sclPullLow}, 3'b100);
    busStop();

    // R4 sweep of write addresses, own 2Ah, broadcast enabled
    regWrite(2'd0, 8'h07);
    for (int a = 0; a < 128; a++) begin
      busStart();
      sendByte({a[6:0], 1'b0}, ackB);
      hit = (a == 'h2A) || (a == 0);
      regRead(2'd1, st);
      check("R4 address sweep", {ackB, irq, st},
            {!hit, hit, hit ? ((a == 0) ? 8'h70 : 8'h60) : 8'hF8});
      if (hit) regWrite(2'd0, 8'h07);
      busStop();
      if (hit) regWrite(2'd0, 8'h07);
    end

    // R12 acknowledge disabled
    regWrite(2'd0, 8'h03);
    busStart(); sendByte(8'h54, ackB);
    check("R12 own address ignored", {ackB, irq}, 2'b10);
    busStop();

    // R4 broadcast address disabled
    regWrite(2'd0, 8'h07);
    regWrite(2'd3, 8'h54);
    busStart(); sendByte(8'h00, ackB);
    check("R4 broadcast off", {ackB, irq}, 2'b10);
    busStop();
    regWrite(2'd3, 8'h55);

    // R6 receive path
    busStart(); sendByte(8'h54, ackB);
    regRead(2'd1, st); check("R4 write address", {ackB, st}, {1'b0, 8'h60});
    check("R7 stretch after address", sclPullLow, 1'b1);
    regWrite(2'd0, 8'h07);
    check("R7 release", sclPullLow, 1'b0);
    sendByte(8'h5A, ackB);
    regRead(2'd1, st); check("R6 ack 80h", {ackB, irq, st}, {1'b0, 1'b1, 8'h80});
    check("R7 stretch after data", sclPullLow, 1'b1);
    regRead(2'd2, d); check("R5 captured", d, 8'h5A);
    regWrite(2'd0, 8'h0F);
    regRead(2'd1, st); check("R3 status held", {irq, st}, {1'b1, 8'h80});
    regWrite(2'd2, 8'hEE);
    regRead(2'd2, d); check("R5 write while flag", d, 8'hEE);
    regWrite(2'd0, 8'h07);
    regRead(2'd1, st); check("R3 clear gives F8h", {irq, st}, {1'b0, 8'hF8});
    sendByte(8'hC3, ackB);
    regRead(2'd2, d); check("R5 second byte", {ackB, d}, {1'b0, 8'hC3});
    regWrite(2'd0, 8'h03);
    sendByte(8'h77, ackB);
    regRead(2'd1, st); check("R6 nack 88h", {ackB, st}, {1'b1, 8'h88});
    regRead(2'd2, d); check("R5 nacked byte", d, 8'h77);
    regWrite(2'd0, 8'h03);
    regRead(2'd1, st); check("R2 idle status", st, 8'hF8);
    regWrite(2'd2, 8'h11);
    regRead(2'd2, d); check("R5 write ignored", d, 8'h77);
    busStop();
    check("R6 skip after nack", irq, 1'b0);

    // R8 transmit path
    regWrite(2'd0, 8'h07);
    busStart(); sendByte(8'h55, ackB);
    regRead(2'd1, st); check("R4 read address", {ackB, st}, {1'b0, 8'hA8});
    regWrite(2'd2, 8'h96);
    regWrite(2'd0, 8'h07);
    recvByte(d, 1'b0);
    check("R8 first byte", d, 8'h96);
    regRead(2'd1, st); check("R8 ack B8h", st, 8'hB8);
    regRead(2'd2, d); check("R5 bus byte", d, 8'h96);
    regWrite(2'd2, 8'h3C);
    regWrite(2'd0, 8'h07);
    recvByte(d, 1'b1);
    check("R8 second byte", d, 8'h3C);
    regRead(2'd1, st); check("R8 nack C0h", st, 8'hC0);
    regWrite(2'd0, 8'h07);
    check("R8 sda released", sdaPullLow, 1'b0);
    recvByte(d, 1'b1);
    check("R8 ignored after nack", {irq, d}, {1'b0, 8'hFF});
    busStop();
    check("R11 no A0 when skipping", irq, 1'b0);

    // R11 repeated start and stop while addressed
    busStart(); sendByte(8'h54, ackB);
    regWrite(2'd0, 8'h07);
    sendByte(8'h12, ackB);
    regWrite(2'd0, 8'h07);
    busStart();
    regRead(2'd1, st); check("R11 repeated start", {irq, sclPullLow, st}, {1'b1, 1'b0, 8'hA0});
    regWrite(2'd0, 8'h07);
    sendByte(8'h54, ackB);
    regRead(2'd1, st); check("R4 after repeated start", {ackB, st}, {1'b0, 8'h60});
    regWrite(2'd0, 8'h07);
    busStop();
    regRead(2'd1, st); check("R11 stop", {irq, sclPullLow, st}, {1'b1, 1'b0, 8'hA0});
    regWrite(2'd0, 8'h07);

    // R10 fully disabled: nothing pulled
    regWrite(2'd0, 8'h00);
    busStart(); sendByte(8'h54, ackB);
    check("R10 core off", {ackB, irq, sclPullLow, sdaPullLow}, 4'b1000);
    busStop();

    check("R9 sda stable while scl high", sdaViol, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule